// File: doc/BRIEF.md
# Adaptive Page-Close Policy Selector

This block picks one of two page-close policies for a DRAM controller. The scheduler reports how each earlier page decision turned out. There are four outcomes: a miss that was avoided by closing, a hit that was gained by keeping the page open, a miss that was caused by keeping the page open, and a hit that was lost by closing too early. The two bad outcomes push a saturating 13-bit mistake score up or down. The two good outcomes leave it alone.

Updates to the score are rate-limited. Between update ticks the bad outcomes are summed into a signed net count. On each tick the score moves by at most one step in the direction of that net, and the net is then cleared.

The selected policy changes only when two conditions hold together: the score has crossed a threshold, and it got there by moving in the matching direction. Between the two thresholds lies a dead band in which the current policy is kept. In normal use, the keep-open policy raises the score and the aggressive-close policy lowers it, so the score settles inside the band.

Top module: `pgpol_adapt`

## Requirements
- R1: While `rst` is high, `cnt_o` loads `cfg_init_i` and `alg_aggr_o` is 0 (keep-open policy). The rate divider and the net accumulator restart from zero.
- R2: Correct-decision strobes (`ev_miss_avoided_i`, `ev_hit_gained_i`) never change `cnt_o` or `alg_aggr_o`.
- R3: `cnt_o` saturates at 0 and at 8191 and never wraps.
- R4: A divider counts 0..`cfg_rate_i`, starting at 0 in the first cycle after reset. `cnt_o` can change only at the clock edge that ends a cycle in which the divider equals `cfg_rate_i`, so a tick occurs once every `cfg_rate_i`+1 cycles.
- R5: Each cycle adds +1 for `ev_miss_caused_i` and −1 for `ev_hit_lost_i`; when both are asserted the cycle contributes 0. The events of the tick cycle itself are included. At a tick, `cnt_o` steps +1 if the net sum is positive, −1 if it is negative, and holds if it is zero. The sum then clears.
- R6: `alg_aggr_o` (1 = aggressive-close policy, 0 = keep-open policy) becomes 1 at a tick whose net sum is positive and whose resulting count is greater than `cfg_hi_thr_i`.
- R7: `alg_aggr_o` becomes 0 at a tick whose net sum is negative and whose resulting count is less than `cfg_lo_thr_i`.
- R8: In every other case `alg_aggr_o` holds. This includes a count inside the dead band, and a count beyond a threshold that is moving in the wrong direction.
- R9: `cnt_vis_o` always equals bits 12..4 of `cnt_o` (the upper 9 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the start count |
| ev_miss_avoided_i | input | 1 | Outcome strobe: a miss was avoided by closing |
| ev_hit_gained_i | input | 1 | Outcome strobe: a hit was gained by keeping open |
| ev_miss_caused_i | input | 1 | Outcome strobe: a miss was caused by keeping open |
| ev_hit_lost_i | input | 1 | Outcome strobe: a hit was lost by closing early |
| cfg_hi_thr_i | input | 13 | Upper threshold that triggers the switch to aggressive close |
| cfg_lo_thr_i | input | 13 | Lower threshold that triggers the switch to keep open |
| cfg_init_i | input | 13 | Start count loaded during reset |
| cfg_rate_i | input | 8 | Tick period minus one, in cycles |
| alg_aggr_o | output | 1 | Selected policy: 1 = aggressive close, 0 = keep open |
| cnt_o | output | 13 | Mistake score |
| cnt_vis_o | output | 9 | Upper 9 bits of the mistake score |

## Verification
A wrong tick phase appears on `cnt_o` within one tick period, because the score then moves one cycle early or late. A wrongly signed or uncleared net sum shows up at the next tick as a step in the wrong direction, or as a step where none should occur. A policy register that ignores the direction qualifier, or compares against the wrong threshold, toggles `alg_aggr_o` at a step where the expected value holds. The bench compares both outputs in every cycle, so each of these faults is reported in the cycle where it first appears.

// File: rtl/pgpol_pkg.sv
`timescale 1ns/1ps
package pgpol_pkg;

  typedef enum logic {
    ALG_KEEP_OPEN = 1'b0,
    ALG_AGGR_CLOSE = 1'b1
  } alg_e;

  // Bit positions of the outcome vector
  localparam int OUT_MISS_AVOIDED = 0;
  localparam int OUT_HIT_GAINED   = 1;
  localparam int OUT_MISS_CAUSED  = 2;
  localparam int OUT_HIT_LOST     = 3;
  localparam int N_OUT            = 4;

  // Score weight of each outcome kind (good outcomes weigh nothing)
  function automatic int outcome_weight(input int kind);
    case (kind)
      OUT_MISS_CAUSED: return 1;
      OUT_HIT_LOST:    return -1;
      default:         return 0;
    endcase
  endfunction

  function automatic int outcome_delta(input logic [N_OUT-1:0] ev);
    int d;
    d = 0;
    for (int k = 0; k < N_OUT; k++) begin
      if (ev[k]) d += outcome_weight(k);
    end
    return d;
  endfunction

  function automatic int sat_add(input int v, input int d, input int lo, input int hi);
    int s;
    s = v + d;
    if (s > hi) return hi;
    if (s < lo) return lo;
    return s;
  endfunction

endpackage

// File: rtl/pgpol_rate_div.sv
`timescale 1ns/1ps
module pgpol_rate_div #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [RATE_W-1:0] div_q;

  assign tick_o = (div_q == rate_i);

  always_ff @(posedge clk) begin
    if (rst)         div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/pgpol_outcome_acc.sv
`timescale 1ns/1ps
module pgpol_outcome_acc
  import pgpol_pkg::*;
#(
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [N_OUT-1:0] ev_i,
  output logic             net_up_o,
  output logic             net_dn_o
);
  localparam int LIM = 2**(ACC_W-1) - 1;

  logic signed [ACC_W-1:0] acc_q;
  int sum_i;

  always_comb begin
    sum_i = sat_add(int'(acc_q), outcome_delta(ev_i), -LIM, LIM);
  end

  assign net_up_o = (sum_i > 0);
  assign net_dn_o = (sum_i < 0);

  always_ff @(posedge clk) begin
    if (rst)         acc_q <= '0;
    else if (tick_i) acc_q <= '0;
    else             acc_q <= ACC_W'(sum_i);
  end
endmodule

// File: rtl/pgpol_mistake_cnt.sv
`timescale 1ns/1ps
module pgpol_mistake_cnt
  import pgpol_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] init_i,
  input  logic             step_up_i,
  input  logic             step_dn_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_d_o
);
  localparam int MAXV = 2**CNT_W - 1;

  logic [CNT_W-1:0] cnt_q;
  int step;

  always_comb begin
    step = 0;
    if (step_up_i)      step = 1;
    else if (step_dn_i) step = -1;
    cnt_d_o = CNT_W'(sat_add(int'(cnt_q), step, 0, MAXV));
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= init_i;
    else     cnt_q <= cnt_d_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pgpol_hyst_sel.sv
`timescale 1ns/1ps
module pgpol_hyst_sel
  import pgpol_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_up_i,
  input  logic             step_dn_i,
  input  logic [CNT_W-1:0] cnt_d_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  output alg_e             alg_o
);
  alg_e alg_q, alg_d;

  always_comb begin
    alg_d = alg_q;
    if (step_up_i && (cnt_d_i > hi_i))      alg_d = ALG_AGGR_CLOSE;
    else if (step_dn_i && (cnt_d_i < lo_i)) alg_d = ALG_KEEP_OPEN;
  end

  always_ff @(posedge clk) begin
    if (rst) alg_q <= ALG_KEEP_OPEN;
    else     alg_q <= alg_d;
  end

  assign alg_o = alg_q;
endmodule

// File: rtl/pgpol_adapt.sv
`timescale 1ns/1ps
module pgpol_adapt
  import pgpol_pkg::*;
#(
  parameter int CNT_W  = 13,
  parameter int VIS_W  = 9,
  parameter int RATE_W = 8,
  parameter int ACC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_miss_avoided_i,
  input  logic              ev_hit_gained_i,
  input  logic              ev_miss_caused_i,
  input  logic              ev_hit_lost_i,
  input  logic [CNT_W-1:0]  cfg_hi_thr_i,
  input  logic [CNT_W-1:0]  cfg_lo_thr_i,
  input  logic [CNT_W-1:0]  cfg_init_i,
  input  logic [RATE_W-1:0] cfg_rate_i,
  output logic              alg_aggr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [VIS_W-1:0]  cnt_vis_o
);
  // Named internal events, exposed for the checker
  logic             upd_tick;
  logic             net_up, net_dn;
  logic             step_up, step_dn;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [N_OUT-1:0] ev_vec;
  alg_e             alg_q;

  always_comb begin
    ev_vec = '0;
    ev_vec[OUT_MISS_AVOIDED] = ev_miss_avoided_i;
    ev_vec[OUT_HIT_GAINED]   = ev_hit_gained_i;
    ev_vec[OUT_MISS_CAUSED]  = ev_miss_caused_i;
    ev_vec[OUT_HIT_LOST]     = ev_hit_lost_i;
  end

  pgpol_rate_div #(.RATE_W(RATE_W)) div_i (
    .clk(clk), .rst(rst), .rate_i(cfg_rate_i), .tick_o(upd_tick)
  );

  pgpol_outcome_acc #(.ACC_W(ACC_W)) acc_i (
    .clk(clk), .rst(rst), .tick_i(upd_tick), .ev_i(ev_vec),
    .net_up_o(net_up), .net_dn_o(net_dn)
  );

  assign step_up = upd_tick & net_up;
  assign step_dn = upd_tick & net_dn;

  pgpol_mistake_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .init_i(cfg_init_i),
    .step_up_i(step_up), .step_dn_i(step_dn),
    .cnt_o(cnt_q), .cnt_d_o(cnt_d)
  );

  pgpol_hyst_sel #(.CNT_W(CNT_W)) sel_i (
    .clk(clk), .rst(rst), .step_up_i(step_up), .step_dn_i(step_dn),
    .cnt_d_i(cnt_d), .hi_i(cfg_hi_thr_i), .lo_i(cfg_lo_thr_i),
    .alg_o(alg_q)
  );

  assign alg_aggr_o = (alg_q == ALG_AGGR_CLOSE);
  assign cnt_o      = cnt_q;
  assign cnt_vis_o  = cnt_q[CNT_W-1 -: VIS_W];
endmodule

// File: rtl/pgpol_adapt_chk.sv
`timescale 1ns/1ps
module pgpol_adapt_chk #(
  parameter int CNT_W = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             step_up,
  input logic             step_dn,
  input logic [CNT_W-1:0] cnt,
  input logic             aggr,
  input logic [CNT_W-1:0] hi,
  input logic [CNT_W-1:0] lo,
  input logic [CNT_W-1:0] init
);
  localparam logic [CNT_W-1:0] MAXC = '1;

  p_init_r1: assert property (@(posedge clk)
    rst |=> (cnt == $past(init)) && !aggr);

  p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (!step_up && !step_dn) |=> $stable(cnt) && $stable(aggr));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt == MAXC) |=> (cnt != '0));

  p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |=> (cnt != MAXC));

  p_hold_between_ticks_r4: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  p_unit_up_r5: assert property (@(posedge clk) disable iff (rst)
    (step_up && cnt != MAXC) |=> (cnt == $past(cnt) + 1'b1));

  p_unit_dn_r5: assert property (@(posedge clk) disable iff (rst)
    (step_dn && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  p_to_aggr_r6: assert property (@(posedge clk) disable iff (rst)
    !aggr |=> (!aggr || ($past(step_up) && cnt > hi)));

  p_to_keep_r7: assert property (@(posedge clk) disable iff (rst)
    aggr |=> (aggr || ($past(step_dn) && cnt < lo)));
endmodule

bind pgpol_adapt pgpol_adapt_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .tick(upd_tick), .step_up(step_up), .step_dn(step_dn),
  .cnt(cnt_o), .aggr(alg_aggr_o), .hi(cfg_hi_thr_i), .lo(cfg_lo_thr_i),
  .init(cfg_init_i)
);

// File: tb/pgpol_adapt_tb_top.sv
`timescale 1ns/1ps
module pgpol_adapt_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ma = 1'b0, hg = 1'b0, mc = 1'b0, hl = 1'b0;
  logic [12:0] hi_thr = 13'd4100, lo_thr = 13'd4090, init_v = 13'd4096;
  logic [7:0]  rate = 8'd0;
  logic        aggr;
  logic [12:0] cnt;
  logic [8:0]  vis;

  always #2.5 clk = ~clk;

  pgpol_adapt dut_i (
    .clk(clk), .rst(rst),
    .ev_miss_avoided_i(ma), .ev_hit_gained_i(hg),
    .ev_miss_caused_i(mc), .ev_hit_lost_i(hl),
    .cfg_hi_thr_i(hi_thr), .cfg_lo_thr_i(lo_thr),
    .cfg_init_i(init_v), .cfg_rate_i(rate),
    .alg_aggr_o(aggr), .cnt_o(cnt), .cnt_vis_o(vis)
  );

  typedef struct {
    int    cnt;
    int    sel;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  // Independent reference model state
  int m_cnt, m_sel, m_net, m_phase;

  task automatic push(input string tag);
    exp_t e;
    e.cnt = m_cnt;
    e.sel = m_sel;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic do_reset(input int iv, input int h, input int l, input int r);
    @(negedge clk);
    rst = 1'b1; ma = 0; hg = 0; mc = 0; hl = 0;
    init_v = 13'(iv); hi_thr = 13'(h); lo_thr = 13'(l); rate = 8'(r);
    @(posedge clk);
    @(negedge clk);
    @(posedge clk); #1;
    m_cnt = iv; m_sel = 0; m_net = 0; m_phase = 0;
    push("R1");
  endtask

  // One cycle: drive the strobes, predict the state after the edge
  task automatic step(input bit a_mc, input bit a_hl, input bit a_ma,
                      input bit a_hg, input string tag);
    @(negedge clk);
    rst = 1'b0;
    mc = a_mc; hl = a_hl; ma = a_ma; hg = a_hg;
    @(posedge clk); #1;
    m_net = m_net + (a_mc ? 1 : 0) - (a_hl ? 1 : 0);
    if (m_phase == int'(rate)) begin
      if (m_net > 0) begin
        if (m_cnt < 8191) m_cnt++;
        if (m_cnt > int'(hi_thr)) m_sel = 1;
      end else if (m_net < 0) begin
        if (m_cnt > 0) m_cnt--;
        if (m_cnt < int'(lo_thr)) m_sel = 0;
      end
      m_net = 0;
      m_phase = 0;
    end else begin
      m_phase++;
    end
    push(tag);
  endtask

  // Monitor: compare one expected item per cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_checks++;
      if (int'(cnt) != e.cnt || int'(aggr) != e.sel) begin
        n_fails++;
        $display("FAIL %s: cnt=%0d sel=%0d expected cnt=%0d sel=%0d",
                 e.tag, cnt, aggr, e.cnt, e.sel);
      end
      if (int'(vis) != (e.cnt >> 4)) begin
        n_fails++;
        $display("FAIL R9: vis=%0d expected %0d", vis, e.cnt >> 4);
      end
    end
  end

  initial begin
    // Hysteresis walk, update every cycle
    do_reset(4096, 4100, 4090, 0);
    for (int i = 0; i < 6; i++) step(0, 0, i[0], ~i[0], "R2");
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, "R6");
    for (int i = 0; i < 11; i++) step(0, 1, 0, 0, "R8");
    for (int i = 0; i < 2; i++) step(0, 1, 0, 0, "R7");
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "R8");
    step(1, 1, 0, 0, "R5");

    // Saturation at the top
    do_reset(8190, 100, 50, 0);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, "R3");
    step(0, 1, 0, 0, "R8");
    // Saturation at the bottom
    do_reset(1, 4000, 50, 0);
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, "R3");
    step(1, 0, 0, 0, "R3");

    // Rate-limited accumulation, tick every 4 cycles
    do_reset(1000, 2000, 10, 3);
    step(1, 0, 0, 0, "R4"); step(1, 0, 0, 0, "R4");
    step(0, 1, 0, 0, "R4"); step(1, 0, 0, 0, "R5");
    step(1, 0, 0, 0, "R4"); step(0, 1, 0, 0, "R4");
    step(0, 0, 0, 0, "R4"); step(0, 0, 0, 0, "R5");
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0, "R5");
    step(0, 1, 0, 0, "R4"); step(0, 1, 0, 0, "R4");
    step(0, 0, 0, 0, "R4"); step(0, 0, 0, 0, "R5");
    for (int i = 0; i < 8; i++) step(0, 0, 1, 1, "R2");
    step(0, 0, 0, 0, "R4"); step(0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, "R4"); step(1, 0, 0, 0, "R5");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule